// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a small circular queue that holds stores which have been issued but whose data-cache update has not happened yet. A store enters in two separate steps. First an address step takes a free slot, records the address and hands back a slot tag. Later a data step names that tag and deposits the store data. A store stays in the queue until the oldest slot has its data and the cache write port accepts it. Only then is it complete and its slot freed.

Every load searches all occupied slots for an equal address. When the youngest matching slot already has data, the load is answered from the queue. When the youngest matching slot still waits for data, the load is told to stall. When nothing matches, the load is told to bypass the queue and go to memory. Stores never wait on each other. The only back-pressure is a ready signal that drops when all slots are taken.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, `wr_valid` is 0 and no load finds a match.
- R2: An address step is accepted in a cycle where `alloc_valid` and `alloc_ready` are both 1. The slot it takes is the value of `alloc_tag` in that cycle. Tags are handed out as 0, 1, ..., DEPTH-1 and then wrap to 0.
- R3: With DEPTH (default 8) slots occupied, `alloc_ready` is 0. An address step offered then is dropped and leaves no trace that a load could find.
- R4: A data step (`fill_valid`, `fill_tag`, `fill_data`) writes the data of an occupied slot that has no data yet. A data step aimed at a free slot, or at a slot that already holds data, is ignored.
- R5: While `ld_valid` is 1, exactly one of `ld_fwd`, `ld_stall` and `ld_bypass` is 1. While `ld_valid` is 0, all three are 0.
- R6: If the youngest occupied slot whose address equals `ld_addr` holds data, `ld_fwd` is 1 and `ld_data` carries that data. This holds even when older matches exist.
- R7: If the youngest matching slot has no data yet, `ld_stall` is 1. This holds even when an older matching slot has data.
- R8: If no occupied slot matches, `ld_bypass` is 1 and `ld_data` is 0.
- R9: `wr_valid` is 1 exactly when the oldest slot holds data. `wr_addr`/`wr_data` then show that slot. Younger slots never reach the write port first. While `wr_ready` is 0, the offered store stays unchanged.
- R10: A slot is freed on the cycle where `wr_valid` and `wr_ready` are both 1. A load in that same cycle still sees the slot. An address step in that same cycle is accepted if the queue was not full.
- R11: A load is judged on the queue contents at the start of its cycle. A data step or address step in the same cycle does not affect that load's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Address step offered |
| alloc_addr | input | ADDR_W | Store address |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | log2(DEPTH) | Slot the next accepted address step takes |
| fill_valid | input | 1 | Data step offered |
| fill_tag | input | log2(DEPTH) | Slot the data belongs to |
| fill_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load address |
| ld_fwd | output | 1 | Load answered from the queue |
| ld_stall | output | 1 | Load must wait for missing store data |
| ld_bypass | output | 1 | No match, load goes to memory |
| ld_data | output | DATA_W | Forwarded data, 0 unless `ld_fwd` |
| wr_valid | output | 1 | Oldest store ready for the cache |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Address of the store being written |
| wr_data | output | DATA_W | Data of the store being written |

## Verification
The sharpest overlap is between a load lookup and the drain of the slot that load matches. Both act on the oldest entry in one cycle: the load must still be forwarded from it, while the handshake frees it. The bench provokes this by raising `wr_ready` and a load to the head address together. A second case in the same cycle offers a new address step that reuses the slot numbering after wrap. The bench then checks three things: the forwarded data, that the tag is accepted, and that a later load to the drained address bypasses. A scoreboard queue holds each store in allocation order. A monitor compares every handshake on the write port against it, so any reordering or data loss on the drain side shows as a mismatch.

// File: rtl/sfb_pkg.sv
// Shared definitions for the store buffer with load forwarding.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sfb_pkg;

    // Default sizing used by the top module.
    localparam int SFB_DEPTH_DEF  = 8;
    localparam int SFB_ADDR_W_DEF = 32;
    localparam int SFB_DATA_W_DEF = 32;

    // Outcome of one load search.
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_MISS = 2'd1,
        LK_FWD  = 2'd2,
        LK_WAIT = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/sfb_ptr_ctrl.sv
// Head/tail pointer and occupancy control for the circular slot queue.
// Does: advances tail on push, head on pop, keeps an occupancy count.
// Assumes: caller never pushes when full nor pops when empty; DEPTH >= 2.
module sfb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;

    // Advance the oldest-slot pointer on each drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (pop) begin
            head <= (head == LAST_PTR) ? '0 : head + 1'b1;
        end
    end

    // Advance the next-free-slot pointer on each allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (push) begin
            tail <= (tail == LAST_PTR) ? '0 : tail + 1'b1;
        end
    end

    // Track occupancy; simultaneous push and pop leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push && !pop) begin
            count <= count + 1'b1;
        end else if (pop && !push) begin
            count <= count - 1'b1;
        end
    end

    // Full flag from occupancy.
    always_comb begin
        full = (count == FULL_CNT);
    end

endmodule

// File: rtl/sfb_entry_array.sv
// Storage for the store slots: occupied bit, data-present bit, address, data.
// Does: marks a slot occupied on allocation, sets data once on the first
// data step to an occupied empty slot, frees the head slot on drain.
// Assumes: push and pop never target the same slot in one cycle.
module sfb_entry_array #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [PTR_W-1:0]              tail,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic                          fill_en,
    input  logic [PTR_W-1:0]              fill_tag,
    input  logic [DATA_W-1:0]             fill_data,
    input  logic                          pop,
    input  logic [PTR_W-1:0]              head,
    output logic [DEPTH-1:0]              ent_vld,
    output logic [DEPTH-1:0]              ent_dv,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_data
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(g);

        logic take_slot;
        logic fill_slot;
        logic free_slot;

        // Decode which events touch this slot.
        always_comb begin
            take_slot = push && (tail == MY_IDX);
            free_slot = pop && (head == MY_IDX);
            fill_slot = fill_en && (fill_tag == MY_IDX) && ent_vld[g] && !ent_dv[g];
        end

        // Occupied and data-present flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_dv[g]  <= 1'b0;
            end else if (free_slot) begin
                ent_vld[g] <= 1'b0;
                ent_dv[g]  <= 1'b0;
            end else if (take_slot) begin
                ent_vld[g] <= 1'b1;
                ent_dv[g]  <= 1'b0;
            end else if (fill_slot) begin
                ent_dv[g]  <= 1'b1;
            end
        end

        // Address and data payload, no reset needed.
        always_ff @(posedge clk) begin
            if (take_slot) begin
                ent_addr[g] <= push_addr;
            end
            if (fill_slot) begin
                ent_data[g] <= fill_data;
            end
        end
    end

endmodule

// File: rtl/sfb_lookup.sv
// Associative load search across all occupied slots.
// Does: walks slots from oldest to youngest so the youngest match wins,
// then classifies the load as forward, wait or miss.
// Assumes: head points at the oldest slot; slot state is registered.
module sfb_lookup
    import sfb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                          ld_valid,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [PTR_W-1:0]              head,
    input  logic [DEPTH-1:0]              ent_vld,
    input  logic [DEPTH-1:0]              ent_dv,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output lk_kind_e                      kind,
    output logic [DATA_W-1:0]             fwd_data
);

    logic             found;
    logic [PTR_W-1:0] sel;

    // Age-ordered scan: later (younger) matches overwrite earlier ones.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int pos;
            pos = int'(head) + k;
            if (pos >= DEPTH) begin
                pos = pos - DEPTH;
            end
            if (ent_vld[pos] && (ent_addr[pos] == ld_addr)) begin
                found = 1'b1;
                sel   = PTR_W'(pos);
            end
        end
    end

    // Classify the load and pick the forwarded data.
    always_comb begin
        kind     = LK_IDLE;
        fwd_data = '0;
        if (ld_valid) begin
            if (!found) begin
                kind = LK_MISS;
            end else if (ent_dv[sel]) begin
                kind     = LK_FWD;
                fwd_data = ent_data[sel];
            end else begin
                kind = LK_WAIT;
            end
        end
    end

endmodule

// File: rtl/store_fwd_buffer.sv
// Store buffer with load forwarding: top level.
// Does: two-step store entry (address, then data by tag), associative load
// search with forward/stall/bypass outcome, in-order drain to a cache port.
// Assumes: loads see the state at the start of the cycle; the cache port
// holds wr_ready independent of wr_valid.
module store_fwd_buffer
    import sfb_pkg::*;
#(
    parameter int DEPTH  = SFB_DEPTH_DEF,
    parameter int ADDR_W = SFB_ADDR_W_DEF,
    parameter int DATA_W = SFB_DATA_W_DEF,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_tag,
    input  logic              fill_valid,
    input  logic [PTR_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_fwd,
    output logic              ld_stall,
    output logic              ld_bypass,
    output logic [DATA_W-1:0] ld_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic                         full;
    logic                         push;
    logic                         pop;
    logic [PTR_W-1:0]             head;
    logic [PTR_W-1:0]             tail;
    logic [DEPTH-1:0]             ent_vld;
    logic [DEPTH-1:0]             ent_dv;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    lk_kind_e                     kind;

    // Handshake decode for allocation and drain.
    always_comb begin
        alloc_ready = !full;
        alloc_tag   = tail;
        push        = alloc_valid && !full;
        wr_valid    = ent_vld[head] && ent_dv[head];
        wr_addr     = ent_addr[head];
        wr_data     = ent_data[head];
        pop         = wr_valid && wr_ready;
    end

    // Load outcome flags.
    always_comb begin
        ld_fwd    = (kind == LK_FWD);
        ld_stall  = (kind == LK_WAIT);
        ld_bypass = (kind == LK_MISS);
    end

    sfb_ptr_ctrl #(
        .DEPTH (DEPTH)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .full  (full)
    );

    sfb_entry_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .tail      (tail),
        .push_addr (alloc_addr),
        .fill_en   (fill_valid),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .pop       (pop),
        .head      (head),
        .ent_vld   (ent_vld),
        .ent_dv    (ent_dv),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    sfb_lookup #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_lookup (
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .head     (head),
        .ent_vld  (ent_vld),
        .ent_dv   (ent_dv),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .kind     (kind),
        .fwd_data (ld_data)
    );

endmodule

// File: rtl/store_fwd_buffer_chk.sv
// Port-level property checker for store_fwd_buffer, attached by bind.
// Does: keeps its own occupancy count from the handshakes and checks
// ready, tag sequence, load outcome and drain stability.
// Assumes: synchronous active-low reset on rst_n.
module store_fwd_buffer_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic              alloc_ready,
    input logic [PTR_W-1:0]  alloc_tag,
    input logic              fill_valid,
    input logic [PTR_W-1:0]  fill_tag,
    input logic [DATA_W-1:0] fill_data,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              ld_fwd,
    input logic              ld_stall,
    input logic              ld_bypass,
    input logic [DATA_W-1:0] ld_data,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    logic [CNT_W-1:0] occ;
    logic             acc;
    logic             drn;

    // Handshake events seen at the ports.
    always_comb begin
        acc = alloc_valid && alloc_ready;
        drn = wr_valid && wr_ready;
    end

    // Independent occupancy count from port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (acc && !drn) begin
            occ <= occ + 1'b1;
        end else if (drn && !acc) begin
            occ <= occ - 1'b1;
        end
    end

    AST_READY_VS_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready == (occ != CNT_W'(DEPTH))); // R3

    AST_TAG_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (alloc_tag == ((($past(alloc_tag) == PTR_W'(DEPTH - 1))) ? '0 : $past(alloc_tag) + 1'b1))); // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($countones({ld_fwd, ld_stall, ld_bypass}) == 1)); // R5

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !(ld_fwd || ld_stall || ld_bypass)); // R5

    AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ld_bypass |-> (ld_data == '0)); // R8

    AST_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

    AST_EMPTY_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !wr_valid); // R1

endmodule

bind store_fwd_buffer store_fwd_buffer_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/store_fwd_buffer_test.sv
`timescale 1ns/1ps
// Scoreboard bench for store_fwd_buffer: the driver records each accepted
// store in allocation order, a monitor checks every drain handshake.
module store_fwd_buffer_test;

    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int PW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic          alloc_ready;
    logic [PW-1:0] alloc_tag;
    logic          fill_valid = 1'b0;
    logic [PW-1:0] fill_tag = '0;
    logic [DW-1:0] fill_data = '0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_fwd, ld_stall, ld_bypass;
    logic [DW-1:0] ld_data;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int bad = 0;

    // Scoreboard state: serial numbers in allocation order.
    int            exp_q[$];
    logic [AW-1:0] ser_addr[int];
    logic [DW-1:0] ser_data[int];
    bit            ser_dv[int];
    int            ser_tag[int];
    int            tag_ser[DEPTH];
    bit            tag_live[DEPTH];
    int            next_ser = 0;

    always #2.5 clk = ~clk;

    store_fwd_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_fwd(ld_fwd), .ld_stall(ld_stall), .ld_bypass(ld_bypass), .ld_data(ld_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Drive one address step; record it in the scoreboard if accepted.
    task automatic do_alloc(input logic [AW-1:0] a, output int tag, output bit took);
        alloc_valid = 1'b1;
        alloc_addr  = a;
        #0.5;
        took = alloc_ready;
        tag  = int'(alloc_tag);
        if (took) begin
            ser_addr[next_ser] = a;
            ser_dv[next_ser]   = 1'b0;
            ser_tag[next_ser]  = tag;
            tag_ser[tag]       = next_ser;
            tag_live[tag]      = 1'b1;
            exp_q.push_back(next_ser);
            next_ser++;
        end
        step();
        alloc_valid = 1'b0;
    endtask

    // Drive one data step; the model keeps only the first data of a live slot.
    task automatic do_fill(input int tag, input logic [DW-1:0] d);
        fill_valid = 1'b1;
        fill_tag   = PW'(tag);
        fill_data  = d;
        if (tag_live[tag] && !ser_dv[tag_ser[tag]]) begin
            ser_data[tag_ser[tag]] = d;
            ser_dv[tag_ser[tag]]   = 1'b1;
        end
        step();
        fill_valid = 1'b0;
    endtask

    // Combinational load probe within the current cycle. kind: 0 bypass, 1 fwd, 2 stall.
    task automatic probe(input logic [AW-1:0] a, input int kind, input logic [DW-1:0] d, input string req);
        ld_valid = 1'b1;
        ld_addr  = a;
        #0.5;
        chk({ld_bypass, ld_fwd, ld_stall} == ((kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001),
            req, {ld_bypass, ld_fwd, ld_stall}, kind);
        if (kind != 2) chk(ld_data == d, req, ld_data, d);
        ld_valid = 1'b0;
        #0.5;
    endtask

    // Monitor: every drain handshake must match the oldest recorded store.
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected drain", wr_addr, 0);
            end else begin
                int s;
                s = exp_q.pop_front();
                chk(wr_addr == ser_addr[s], "R9 drain addr", wr_addr, ser_addr[s]);
                chk(ser_dv[s] && wr_data == ser_data[s], "R9 drain data", wr_data, ser_data[s]);
                tag_live[ser_tag[s]] = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R9 watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int t;
        bit ok;
        for (int i = 0; i < DEPTH; i++) begin
            tag_live[i] = 1'b0;
            tag_ser[i]  = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;

        // R1 reset state
        chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
        chk(alloc_tag == '0, "R1 tag", alloc_tag, 0);
        chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
        probe(32'h100, 0, 0, "R1 empty lookup");

        // R2 tag sequence
        do_alloc(32'h100, t, ok);
        chk(ok && t == 0, "R2 first tag", t, 0);
        do_alloc(32'h200, t, ok);
        chk(ok && t == 1, "R2 second tag", t, 1);

        // R7 stall, R8 bypass, R5 idle quiet
        probe(32'h100, 2, 0, "R7 no data yet");
        probe(32'h300, 0, 0, "R8 miss");
        #0.5;
        chk({ld_fwd, ld_stall, ld_bypass} == 3'b000, "R5 idle", {ld_fwd, ld_stall, ld_bypass}, 0);
        chk(wr_valid == 1'b0, "R9 head lacks data", wr_valid, 0);

        // R6 forward from tag1; R9 younger slot waits behind head
        do_fill(1, 32'hB1);
        probe(32'h200, 1, 32'hB1, "R6 forward");
        chk(wr_valid == 1'b0, "R9 in order", wr_valid, 0);

        // R11 same-cycle fill does not affect load
        fill_valid = 1'b1; fill_tag = 0; fill_data = 32'hA0;
        ser_data[tag_ser[0]] = 32'hA0; ser_dv[tag_ser[0]] = 1'b1;
        probe(32'h100, 2, 0, "R11 fill same cycle");
        step();
        fill_valid = 1'b0;
        probe(32'h100, 1, 32'hA0, "R6 after fill");
        chk(wr_valid && wr_addr == 32'h100, "R9 head offered", wr_addr, 32'h100);

        // R4 duplicate fill ignored
        do_fill(0, 32'hEE);
        probe(32'h100, 1, 32'hA0, "R4 second fill");
        // R4 fill to a free slot ignored (checked once slot 5 is taken)
        do_fill(5, 32'h55);

        // R7/R6 youngest match decides
        do_alloc(32'h100, t, ok);
        chk(t == 2, "R2 third tag", t, 2);
        probe(32'h100, 2, 0, "R7 youngest lacks data");
        do_fill(2, 32'hC2);
        probe(32'h100, 1, 32'hC2, "R6 youngest wins");

        // Fill the rest of the slots; R3 full
        for (int i = 3; i < DEPTH; i++) begin
            do_alloc(32'h400 + AW'(i), t, ok);
            chk(ok && t == i, "R2 tag run", t, i);
        end
        probe(32'h405, 2, 0, "R4 free-slot fill ignored");
        chk(alloc_ready == 1'b0, "R3 full", alloc_ready, 0);
        do_alloc(32'h999, t, ok);
        chk(!ok, "R3 refused", ok, 0);
        probe(32'h999, 0, 0, "R3 dropped store");
        chk(alloc_tag == '0, "R3 tag wrapped", alloc_tag, 0);
        for (int i = 3; i < DEPTH; i++) do_fill(i, 32'hD0 + DW'(i));

        // R9 held while not ready
        step();
        chk(wr_valid && wr_addr == 32'h100 && wr_data == 32'hA0, "R9 held", wr_data, 32'hA0);

        // Drain head (tag0)
        wr_ready = 1'b1;
        step();
        // R10 same cycle: drain tag1, load to it, new allocation
        ld_valid = 1'b1; ld_addr = 32'h200;
        #0.5;
        chk(ld_fwd && ld_data == 32'hB1, "R10 load sees draining slot", ld_data, 32'hB1);
        ld_valid = 1'b0;
        do_alloc(32'h600, t, ok);
        chk(ok && t == 0, "R10 alloc with drain", t, 0);
        wr_ready = 1'b0;
        #0.5;
        probe(32'h200, 0, 0, "R10 freed slot");
        chk(alloc_ready && alloc_tag == 1, "R10 occupancy kept", alloc_tag, 1);
        probe(32'h600, 2, 0, "R7 new store no data");
        do_fill(0, 32'h66);

        // Drain everything
        wr_ready = 1'b1;
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) step();
        wr_ready = 1'b0;
        step();
        chk(exp_q.size() == 0, "R9 all drained", exp_q.size(), 0);
        chk(alloc_ready && !wr_valid, "R1 empty again", wr_valid, 0);
        probe(32'h600, 0, 0, "R10 drained store gone");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule